// File: doc/BRIEF.md
# Link Reset Handshake Sequencer

This block coordinates the reset of one serial link's transmit and receive paths. Each direction accepts a reset request from outside the clock domain. The block answers with an in-reset indication once the physical-layer status shows that the path is really held in reset. It withdraws that indication only after the request is released. Both directions run fully independently. A request that is withdrawn before it is answered is recorded as a sticky handshake error.

When forward error correction is built in (`FEC_EN`), each release of the transmit path opens a second handshake. The block raises a marker-start request and waits for the marker-sent acknowledge, which means at least two alignment markers have gone out. A configurable timer flags an acknowledge that never arrives. Transmit ready waits for the physical layer, the datapath and, with FEC, this marker handshake. Receive ready waits for the physical layer, the datapath and, when `DESKEW_EN` is set, the deskew-done level.

Every level input passes through a synchronizer of `SYNC_STAGES` flops, two by default, before any decision uses it. All outputs are registers.

Top module: `link_rst_seq`

## Requirements
- R1: `tx_in_rst` rises only one clock after the synchronized `tx_rst_req` is high while both synchronized `tx_pma_done` and `tx_dp_done` are low. It stays high while the request is held. It falls one clock after the synchronized request is seen low, and it stays low while the request stays low.
- R2: `rx_in_rst` follows the same rule as R1 against `rx_rst_req`, `rx_pma_done` and `rx_dp_done`. The transmit side has no effect on it.
- R3: If a direction's synchronized request drops before its in-reset indication has risen, that direction's handshake error flag (`tx_hs_err` or `rx_hs_err`) is set. The flag stays set until the next request of that direction is seen. In that case the direction proceeds as if the reset had been released.
- R4: With FEC built in, after every transmit release and after system reset, `mrk_req` rises. It falls one clock after the synchronized `mrk_ack` is seen high. A new transmit request also clears it.
- R5: `mrk_req` is never raised while the synchronized `mrk_ack` is still high from a previous handshake. The block waits for the acknowledge to fall first.
- R6: `tx_rdy` is high only while the transmit path is running and both transmit done levels are high. With FEC built in, the marker handshake since the last release must also have completed.
- R7: `rx_rdy` is high only while the receive path is running and both receive done levels are high. When `DESKEW_EN` is set, `rx_deskew_done` must be high as well.
- R8: With FEC built in, if `mrk_req` has been high for `MRK_TIMEOUT` clocks without an acknowledge, `mrk_tmo_err` is set. It stays set until the next transmit request is seen.
- R9: While `rst` is high, all outputs are low. An input change reaches an output no earlier than the third rising clock edge after it.
- R10: One clock after a synchronized reset request of a direction is seen, that direction's ready output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_rst_req | input | 1 | Asynchronous transmit reset request |
| rx_rst_req | input | 1 | Asynchronous receive reset request |
| tx_pma_done | input | 1 | Transmit physical layer out of reset |
| tx_dp_done | input | 1 | Transmit datapath out of reset |
| rx_pma_done | input | 1 | Receive physical layer out of reset |
| rx_dp_done | input | 1 | Receive datapath out of reset |
| rx_deskew_done | input | 1 | Receive lane deskew complete |
| mrk_ack | input | 1 | At least two alignment markers sent |
| tx_in_rst | output | 1 | Transmit path fully held in reset |
| rx_in_rst | output | 1 | Receive path fully held in reset |
| mrk_req | output | 1 | Request to start alignment markers |
| tx_rdy | output | 1 | Transmit path ready for data |
| rx_rdy | output | 1 | Receive path ready for data |
| tx_hs_err | output | 1 | Sticky transmit handshake error |
| rx_hs_err | output | 1 | Sticky receive handshake error |
| mrk_tmo_err | output | 1 | Sticky marker acknowledge timeout |

## Verification
The assertions check the per-cycle relations on every clock. An in-reset edge must always be preceded by the matching synchronized request level. Ready may only follow satisfied done levels, and it must drop after a request. A marker request may not rise over a stale acknowledge, and the error flags stay sticky while no request is present.

Only the bench scenarios can show the sequences that span many cycles. These include the exact cycle at which the marker timeout fires, recovery after an aborted request, and the independence of the two directions. They also cover the deskew gating of receive ready and the three-edge latency from port to output. For these the bench compares against its cycle-accurate reference on every clock.

// File: rtl/link_rst_pkg.sv
package link_rst_pkg;

  typedef enum logic [2:0] {
    PS_RUN,
    PS_ENTER,
    PS_HELD,
    PS_MGAP,
    PS_MREQ
  } path_st_t;

  localparam int NUM_IN = 8;
  localparam int IX_TXREQ = 7;
  localparam int IX_RXREQ = 6;
  localparam int IX_TXPMA = 5;
  localparam int IX_TXDP  = 4;
  localparam int IX_RXPMA = 3;
  localparam int IX_RXDP  = 2;
  localparam int IX_DSK   = 1;
  localparam int IX_MACK  = 0;

endpackage

// File: rtl/link_rst_sync.sv
module link_rst_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/link_rst_tx.sv
module link_rst_tx
  import link_rst_pkg::*;
#(
  parameter bit FEC_EN      = 1'b1,
  parameter int MRK_TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic req_s,
  input  logic pma_s,
  input  logic dp_s,
  input  logic mack_s,
  output logic in_rst,
  output logic mrk_req,
  output logic rdy,
  output logic hs_err,
  output logic tmo_err
);

  localparam int TW = $clog2(MRK_TIMEOUT + 1);
  localparam logic [TW-1:0] TMO_LAST = TW'(MRK_TIMEOUT - 1);
  localparam path_st_t AFTER_REL = FEC_EN ? PS_MGAP : PS_RUN;

  path_st_t st;
  logic mrk_ok;
  logic [TW-1:0] tmo_cnt;
  logic holding;
  logic ready_ok;

  always_comb begin
    holding  = (st == PS_ENTER) || (st == PS_HELD);
    ready_ok = pma_s && dp_s && (!FEC_EN || mrk_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= AFTER_REL;
      in_rst  <= 1'b0;
      mrk_req <= 1'b0;
      rdy     <= 1'b0;
      hs_err  <= 1'b0;
      tmo_err <= 1'b0;
      mrk_ok  <= 1'b0;
      tmo_cnt <= '0;
    end else begin
      rdy <= 1'b0;
      if (req_s && !holding) begin
        st      <= PS_ENTER;
        mrk_req <= 1'b0;
        mrk_ok  <= 1'b0;
        hs_err  <= 1'b0;
        tmo_err <= 1'b0;
      end else begin
        case (st)
          PS_RUN: rdy <= ready_ok;
          PS_ENTER: begin
            if (!req_s) begin
              hs_err <= 1'b1;
              st     <= AFTER_REL;
            end else if (!pma_s && !dp_s) begin
              in_rst <= 1'b1;
              st     <= PS_HELD;
            end
          end
          PS_HELD: begin
            if (!req_s) begin
              in_rst <= 1'b0;
              st     <= AFTER_REL;
            end
          end
          PS_MGAP: begin
            if (!mack_s) begin
              mrk_req <= 1'b1;
              tmo_cnt <= '0;
              st      <= PS_MREQ;
            end
          end
          PS_MREQ: begin
            if (mack_s) begin
              mrk_req <= 1'b0;
              mrk_ok  <= 1'b1;
              st      <= PS_RUN;
            end else if (tmo_cnt == TMO_LAST) begin
              tmo_err <= 1'b1;
            end else begin
              tmo_cnt <= tmo_cnt + 1'b1;
            end
          end
          default: st <= PS_RUN;
        endcase
      end
    end
  end

  p_ack_rise_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(in_rst) |-> $past(req_s) && !$past(pma_s) && !$past(dp_s));
  p_ack_hold_r1: assert property (@(posedge clk) disable iff (rst)
    in_rst && req_s |=> in_rst);
  p_ack_fall_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(in_rst) |-> !$past(req_s));
  p_err_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    hs_err && !req_s |=> hs_err);
  p_mrk_clear_r4: assert property (@(posedge clk) disable iff (rst)
    mrk_req && mack_s |=> !mrk_req);
  p_mrk_gap_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(mrk_req) |-> !$past(mack_s));
  p_rdy_done_r6: assert property (@(posedge clk) disable iff (rst)
    rdy |-> $past(pma_s) && $past(dp_s) && !in_rst);
  p_tmo_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    tmo_err && !req_s |=> tmo_err);
  p_req_drop_rdy_r10: assert property (@(posedge clk) disable iff (rst)
    req_s |=> !rdy);

endmodule

// File: rtl/link_rst_rx.sv
module link_rst_rx
  import link_rst_pkg::*;
#(
  parameter bit DESKEW_EN = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic req_s,
  input  logic pma_s,
  input  logic dp_s,
  input  logic dsk_s,
  output logic in_rst,
  output logic rdy,
  output logic hs_err
);

  path_st_t st;
  logic holding;
  logic ready_ok;

  always_comb begin
    holding  = (st == PS_ENTER) || (st == PS_HELD);
    ready_ok = pma_s && dp_s && (!DESKEW_EN || dsk_s);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= PS_RUN;
      in_rst <= 1'b0;
      rdy    <= 1'b0;
      hs_err <= 1'b0;
    end else begin
      rdy <= 1'b0;
      if (req_s && !holding) begin
        st     <= PS_ENTER;
        hs_err <= 1'b0;
      end else begin
        case (st)
          PS_RUN: rdy <= ready_ok;
          PS_ENTER: begin
            if (!req_s) begin
              hs_err <= 1'b1;
              st     <= PS_RUN;
            end else if (!pma_s && !dp_s) begin
              in_rst <= 1'b1;
              st     <= PS_HELD;
            end
          end
          PS_HELD: begin
            if (!req_s) begin
              in_rst <= 1'b0;
              st     <= PS_RUN;
            end
          end
          default: st <= PS_RUN;
        endcase
      end
    end
  end

  p_ack_rise_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(in_rst) |-> $past(req_s) && !$past(pma_s) && !$past(dp_s));
  p_ack_fall_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(in_rst) |-> !$past(req_s));
  p_err_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    hs_err && !req_s |=> hs_err);
  p_rdy_done_r7: assert property (@(posedge clk) disable iff (rst)
    rdy |-> $past(pma_s) && $past(dp_s) && ($past(dsk_s) || !DESKEW_EN));
  p_req_drop_rdy_r10: assert property (@(posedge clk) disable iff (rst)
    req_s |=> !rdy);

endmodule

// File: rtl/link_rst_seq.sv
module link_rst_seq
  import link_rst_pkg::*;
#(
  parameter bit FEC_EN      = 1'b1,
  parameter bit DESKEW_EN   = 1'b1,
  parameter int SYNC_STAGES = 2,
  parameter int MRK_TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_rst_req,
  input  logic rx_rst_req,
  input  logic tx_pma_done,
  input  logic tx_dp_done,
  input  logic rx_pma_done,
  input  logic rx_dp_done,
  input  logic rx_deskew_done,
  input  logic mrk_ack,
  output logic tx_in_rst,
  output logic rx_in_rst,
  output logic mrk_req,
  output logic tx_rdy,
  output logic rx_rdy,
  output logic tx_hs_err,
  output logic rx_hs_err,
  output logic mrk_tmo_err
);

  logic [NUM_IN-1:0] raw_in;
  logic [NUM_IN-1:0] syn_in;

  always_comb begin
    raw_in           = '0;
    raw_in[IX_TXREQ] = tx_rst_req;
    raw_in[IX_RXREQ] = rx_rst_req;
    raw_in[IX_TXPMA] = tx_pma_done;
    raw_in[IX_TXDP]  = tx_dp_done;
    raw_in[IX_RXPMA] = rx_pma_done;
    raw_in[IX_RXDP]  = rx_dp_done;
    raw_in[IX_DSK]   = rx_deskew_done;
    raw_in[IX_MACK]  = mrk_ack;
  end

  link_rst_sync #(.W(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (syn_in)
  );

  link_rst_tx #(.FEC_EN(FEC_EN), .MRK_TIMEOUT(MRK_TIMEOUT)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .req_s   (syn_in[IX_TXREQ]),
    .pma_s   (syn_in[IX_TXPMA]),
    .dp_s    (syn_in[IX_TXDP]),
    .mack_s  (syn_in[IX_MACK]),
    .in_rst  (tx_in_rst),
    .mrk_req (mrk_req),
    .rdy     (tx_rdy),
    .hs_err  (tx_hs_err),
    .tmo_err (mrk_tmo_err)
  );

  link_rst_rx #(.DESKEW_EN(DESKEW_EN)) u_rx (
    .clk    (clk),
    .rst    (rst),
    .req_s  (syn_in[IX_RXREQ]),
    .pma_s  (syn_in[IX_RXPMA]),
    .dp_s   (syn_in[IX_RXDP]),
    .dsk_s  (syn_in[IX_DSK]),
    .in_rst (rx_in_rst),
    .rdy    (rx_rdy),
    .hs_err (rx_hs_err)
  );

  p_rst_quiet_r9: assert property (@(posedge clk)
    $past(rst) |-> !tx_in_rst && !rx_in_rst && !tx_rdy && !rx_rdy && !tx_hs_err && !rx_hs_err);

endmodule

// File: tb/link_rst_seq_test.sv
`timescale 1ns/1ps
module link_rst_seq_test;

  localparam int TMO = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_rst_req = 0, rx_rst_req = 0, tx_pma_done = 0, tx_dp_done = 0;
  logic rx_pma_done = 0, rx_dp_done = 0, rx_deskew_done = 0, mrk_ack = 0;
  logic tx_in_rst, rx_in_rst, mrk_req, tx_rdy, rx_rdy, tx_hs_err, rx_hs_err, mrk_tmo_err;

  always #5 clk = ~clk;

  link_rst_seq #(.FEC_EN(1'b1), .DESKEW_EN(1'b1), .SYNC_STAGES(2), .MRK_TIMEOUT(TMO)) uut (
    .clk(clk), .rst(rst),
    .tx_rst_req(tx_rst_req), .rx_rst_req(rx_rst_req),
    .tx_pma_done(tx_pma_done), .tx_dp_done(tx_dp_done),
    .rx_pma_done(rx_pma_done), .rx_dp_done(rx_dp_done),
    .rx_deskew_done(rx_deskew_done), .mrk_ack(mrk_ack),
    .tx_in_rst(tx_in_rst), .rx_in_rst(rx_in_rst), .mrk_req(mrk_req),
    .tx_rdy(tx_rdy), .rx_rdy(rx_rdy), .tx_hs_err(tx_hs_err),
    .rx_hs_err(rx_hs_err), .mrk_tmo_err(mrk_tmo_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  int n_cyc = 0;

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at cycle %0d", tag, what, act, exp, n_cyc);
    end
  endtask

  // Reference model: delay queues for the input levels, phases as integers.
  bit q_txreq[$], q_rxreq[$], q_txpma[$], q_txdp[$], q_rxpma[$], q_rxdp[$], q_dsk[$], q_mack[$];
  // phase: 0 running, 1 waiting for path in reset, 2 held, 3 waiting for marker ack low, 4 markers requested
  int  tph, rph, wait_cnt;
  bit  m_txa, m_rxa, m_mreq, m_trdy, m_rrdy, m_terr, m_rerr, m_tmo, m_credit;

  task automatic fill_queues();
    q_txreq = '{0, 0}; q_rxreq = '{0, 0}; q_txpma = '{0, 0}; q_txdp = '{0, 0};
    q_rxpma = '{0, 0}; q_rxdp = '{0, 0}; q_dsk = '{0, 0}; q_mack = '{0, 0};
  endtask

  initial fill_queues();

  always @(posedge clk) begin
    n_cyc++;
    if (rst) begin
      tph = 3; rph = 0; wait_cnt = 0;
      {m_txa, m_rxa, m_mreq, m_trdy, m_rrdy, m_terr, m_rerr, m_tmo, m_credit} = '0;
      fill_queues();
    end else begin
      bit treq, rreq, tpma, tdp, rpma, rdp, dsk, mack;
      treq = q_txreq.pop_front(); rreq = q_rxreq.pop_front();
      tpma = q_txpma.pop_front(); tdp = q_txdp.pop_front();
      rpma = q_rxpma.pop_front(); rdp = q_rxdp.pop_front();
      dsk = q_dsk.pop_front(); mack = q_mack.pop_front();
      // transmit side
      m_trdy = 0;
      if (treq && tph != 1 && tph != 2) begin
        tph = 1; m_mreq = 0; m_credit = 0; m_terr = 0; m_tmo = 0;
      end else if (tph == 0) begin
        m_trdy = tpma && tdp && m_credit;
      end else if (tph == 1) begin
        if (!treq) begin m_terr = 1; tph = 3; end
        else if (!tpma && !tdp) begin m_txa = 1; tph = 2; end
      end else if (tph == 2) begin
        if (!treq) begin m_txa = 0; tph = 3; end
      end else if (tph == 3) begin
        if (!mack) begin m_mreq = 1; wait_cnt = 0; tph = 4; end
      end else begin
        if (mack) begin m_mreq = 0; m_credit = 1; tph = 0; end
        else begin
          wait_cnt++;
          if (wait_cnt >= TMO) m_tmo = 1;
        end
      end
      // receive side
      m_rrdy = 0;
      if (rreq && rph == 0) begin
        rph = 1; m_rerr = 0;
      end else if (rph == 0) begin
        m_rrdy = rpma && rdp && dsk;
      end else if (rph == 1) begin
        if (!rreq) begin m_rerr = 1; rph = 0; end
        else if (!rpma && !rdp) begin m_rxa = 1; rph = 2; end
      end else begin
        if (!rreq) begin m_rxa = 0; rph = 0; end
      end
    end
    q_txreq.push_back(tx_rst_req); q_rxreq.push_back(rx_rst_req);
    q_txpma.push_back(tx_pma_done); q_txdp.push_back(tx_dp_done);
    q_rxpma.push_back(rx_pma_done); q_rxdp.push_back(rx_dp_done);
    q_dsk.push_back(rx_deskew_done); q_mack.push_back(mrk_ack);
    if (rst) begin
      void'(q_txreq.pop_front()); void'(q_rxreq.pop_front()); void'(q_txpma.pop_front());
      void'(q_txdp.pop_front()); void'(q_rxpma.pop_front()); void'(q_rxdp.pop_front());
      void'(q_dsk.pop_front()); void'(q_mack.pop_front());
      q_txreq[1] = 0; q_rxreq[1] = 0; q_txpma[1] = 0; q_txdp[1] = 0;
      q_rxpma[1] = 0; q_rxdp[1] = 0; q_dsk[1] = 0; q_mack[1] = 0;
    end
  end

  // Every-cycle comparison against the reference
  always @(negedge clk) begin
    if (n_cyc > 0) begin
      chk("R1", "tx_in_rst", tx_in_rst, m_txa);
      chk("R2", "rx_in_rst", rx_in_rst, m_rxa);
      chk("R3", "tx_hs_err", tx_hs_err, m_terr);
      chk("R3", "rx_hs_err", rx_hs_err, m_rerr);
      chk("R4", "mrk_req", mrk_req, m_mreq);
      chk("R6", "tx_rdy", tx_rdy, m_trdy);
      chk("R7", "rx_rdy", rx_rdy, m_rrdy);
      chk("R8", "mrk_tmo_err", mrk_tmo_err, m_tmo);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    cyc(4);
    // R9: all outputs low under reset
    chk("R9", "reset tx_in_rst", tx_in_rst, 1'b0);
    chk("R9", "reset mrk_req", mrk_req, 1'b0);
    chk("R9", "reset tx_rdy", tx_rdy, 1'b0);
    chk("R9", "reset rx_rdy", rx_rdy, 1'b0);
    tx_pma_done = 1; tx_dp_done = 1; rx_pma_done = 1; rx_dp_done = 1;
    rst = 0;
    cyc(4);
    chk("R4", "markers requested after reset", mrk_req, 1'b1);
    chk("R6", "tx not ready before markers", tx_rdy, 1'b0);
    chk("R7", "rx waits for deskew", rx_rdy, 1'b0);
    rx_deskew_done = 1;
    mrk_ack = 1;
    cyc(2);
    chk("R9", "ack not yet through sync", mrk_req, 1'b1);
    cyc(4);
    chk("R4", "markers cleared by ack", mrk_req, 1'b0);
    chk("R6", "tx ready after markers", tx_rdy, 1'b1);
    chk("R7", "rx ready with deskew", rx_rdy, 1'b1);
    mrk_ack = 0;
    cyc(3);

    // R1/R10: transmit handshake, path still reporting done
    tx_rst_req = 1;
    cyc(4);
    chk("R10", "tx ready dropped", tx_rdy, 1'b0);
    chk("R1", "ack waits for path in reset", tx_in_rst, 1'b0);
    tx_pma_done = 0; tx_dp_done = 0;
    cyc(5);
    chk("R1", "ack asserted", tx_in_rst, 1'b1);
    chk("R2", "rx unaffected", rx_rdy, 1'b1);
    cyc(5);
    chk("R1", "ack held", tx_in_rst, 1'b1);
    tx_rst_req = 0;
    cyc(5);
    chk("R1", "ack released", tx_in_rst, 1'b0);
    chk("R4", "marker request after release", mrk_req, 1'b1);
    tx_pma_done = 1; tx_dp_done = 1;
    cyc(4);
    chk("R6", "tx waits for markers", tx_rdy, 1'b0);
    mrk_ack = 1;
    cyc(5);
    chk("R6", "tx ready", tx_rdy, 1'b1);
    mrk_ack = 0;
    cyc(3);

    // R5: stale acknowledge still high at release
    tx_rst_req = 1; tx_pma_done = 0; tx_dp_done = 0;
    cyc(6);
    mrk_ack = 1;
    tx_rst_req = 0;
    cyc(8);
    chk("R5", "no request over stale ack", mrk_req, 1'b0);
    mrk_ack = 0;
    cyc(5);
    chk("R5", "request after ack low", mrk_req, 1'b1);
    mrk_ack = 1;
    cyc(5);
    mrk_ack = 0; tx_pma_done = 1; tx_dp_done = 1;
    cyc(5);

    // R8: marker acknowledge timeout
    tx_rst_req = 1; tx_pma_done = 0; tx_dp_done = 0;
    cyc(6);
    tx_rst_req = 0;
    cyc(4);
    chk("R8", "no timeout yet", mrk_tmo_err, 1'b0);
    cyc(TMO + 4);
    chk("R8", "timeout flagged", mrk_tmo_err, 1'b1);
    mrk_ack = 1; tx_pma_done = 1; tx_dp_done = 1;
    cyc(6);
    chk("R8", "timeout sticky", mrk_tmo_err, 1'b1);
    chk("R6", "tx ready after late ack", tx_rdy, 1'b1);
    mrk_ack = 0;
    tx_rst_req = 1;
    cyc(5);
    chk("R8", "timeout cleared by request", mrk_tmo_err, 1'b0);
    tx_pma_done = 0; tx_dp_done = 0;
    cyc(5);
    tx_rst_req = 0;
    cyc(5);
    mrk_ack = 1; tx_pma_done = 1; tx_dp_done = 1;
    cyc(5);
    mrk_ack = 0;
    cyc(3);

    // R3: transmit request dropped before acknowledge
    tx_rst_req = 1;
    cyc(4);
    tx_rst_req = 0;
    cyc(5);
    chk("R3", "tx handshake error", tx_hs_err, 1'b1);
    chk("R1", "no ack on abort", tx_in_rst, 1'b0);
    mrk_ack = 1;
    cyc(5);
    mrk_ack = 0;
    cyc(5);
    chk("R3", "tx error sticky", tx_hs_err, 1'b1);
    tx_rst_req = 1;
    cyc(5);
    chk("R3", "tx error cleared", tx_hs_err, 1'b0);
    tx_rst_req = 0;
    cyc(5);
    mrk_ack = 1;
    cyc(5);
    mrk_ack = 0;

    // R3/R2/R7: receive side
    rx_rst_req = 1;
    cyc(4);
    chk("R10", "rx ready dropped", rx_rdy, 1'b0);
    rx_rst_req = 0;
    cyc(5);
    chk("R3", "rx handshake error", rx_hs_err, 1'b1);
    rx_rst_req = 1; rx_pma_done = 0; rx_dp_done = 0;
    cyc(6);
    chk("R3", "rx error cleared", rx_hs_err, 1'b0);
    chk("R2", "rx ack asserted", rx_in_rst, 1'b1);
    chk("R2", "tx unaffected", tx_in_rst, 1'b0);
    rx_rst_req = 0;
    cyc(5);
    chk("R2", "rx ack released", rx_in_rst, 1'b0);
    rx_pma_done = 1; rx_dp_done = 1;
    cyc(5);
    chk("R7", "rx ready again", rx_rdy, 1'b1);
    rx_deskew_done = 0;
    cyc(4);
    chk("R7", "rx ready follows deskew", rx_rdy, 1'b0);
    rx_deskew_done = 1;
    // single-cycle request pulse
    tx_rst_req = 1;
    cyc(1);
    tx_rst_req = 0;
    cyc(8);
    chk("R3", "short pulse flagged", tx_hs_err, 1'b1);
    cyc(10);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule